// File: doc/BRIEF.md
# Floating-Point Error Ignore Control

This block sits at the issue point of a floating-point unit. It decides whether an instruction offered for issue may run while an unmasked numeric exception is still pending. Two things steer the decision: a mode bit that selects native error reporting, and an external pin that tells the unit to disregard pending numeric errors. A decoded flag marks the non-waiting control instructions. These are initialise, clear exceptions, store control word, store status word, store environment, save state and the three legacy mode-set operations. While an exception is pending, those instructions run anyway.

When native reporting is selected, the pin has no effect. A pending exception raises a report pulse for the native error path and the instruction does not run. With native reporting off and the pin low, any instruction outside the non-waiting class freezes the unit. The unit stays frozen until an external interrupt arrives or reset is applied. All outputs are registered, so each decision appears one clock after the issue cycle that caused it.

Top module: `fp_err_ignore_ctl`

## Requirements
- R1: During and right after reset, `exec_ok`, `stall` and `report_exc` are all 0.
- R2: An issued instruction with `exc_pending`=0 gives `exec_ok`=1 in the following cycle, whatever the values of `native_mode`, `ignore_err` and `nowait_cls`.
- R3: With `native_mode`=1 and `exc_pending`=1, an issued instruction gives `report_exc`=1 and `exec_ok`=0 in the following cycle, never stalls, and `ignore_err` makes no difference.
- R4: With `native_mode`=0, `exc_pending`=1 and `ignore_err`=1, an issued instruction of any class gives `exec_ok`=1 in the following cycle.
- R5: With `native_mode`=0, `exc_pending`=1, `ignore_err`=0 and `nowait_cls`=1, an issued instruction gives `exec_ok`=1 in the following cycle.
- R6: With `native_mode`=0, `exc_pending`=1, `ignore_err`=0 and `nowait_cls`=0, an issued instruction gives `stall`=1 and `exec_ok`=0 from the following cycle on.
- R7: Once `stall` is 1, it stays 1 until `ext_intr` is sampled high. Raising `ignore_err` does not release it. Instructions issued while stalled get neither `exec_ok` nor `report_exc`.
- R8: `ext_intr` sampled high while stalled drops `stall` in the next cycle, and an instruction offered in that same cycle is discarded. `ext_intr` has no effect when the unit is not stalled.
- R9: A cycle with `issue_vld`=0 gives `exec_ok`=0 and `report_exc`=0 in the following cycle.
- R10: At most one of `exec_ok`, `stall` and `report_exc` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| native_mode | input | 1 | 1 selects native numeric error reporting |
| exc_pending | input | 1 | An unmasked numeric exception is pending |
| ignore_err | input | 1 | Request to disregard pending numeric errors, active high |
| issue_vld | input | 1 | A floating-point instruction is offered for issue |
| nowait_cls | input | 1 | The offered instruction belongs to the non-waiting control class |
| ext_intr | input | 1 | External interrupt that releases a stall |
| exec_ok | output | 1 | The instruction issued last cycle may execute |
| stall | output | 1 | Execution is frozen, waiting for an interrupt |
| report_exc | output | 1 | Send the pending exception to the native error path |

## Verification
Each combination of mode bit, pending flag, pin and class flag is issued in turn. This separates the four outcomes: plain execution, native report, override by the pin, and the non-waiting bypass. Stall sequences raise the pin and keep issuing instructions while frozen, to show that only the interrupt releases the unit. Interrupts are also sent when the unit is not stalled, and together with an issue on the release cycle, to show when they act and when they do nothing. Idle cycles between issues confirm that the outputs only follow valid issue cycles.

// File: rtl/fpei_pkg.sv
package fpei_pkg;
  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_EXEC   = 2'd1,
    ACT_REPORT = 2'd2,
    ACT_FREEZE = 2'd3
  } fpei_act_e;
endpackage

// File: rtl/fpei_classify.sv
module fpei_classify
  import fpei_pkg::*;
(
  input  logic      issue_vld,
  input  logic      native_mode,
  input  logic      exc_pending,
  input  logic      ignore_err,
  input  logic      nowait_cls,
  output fpei_act_e act
);
  always_comb begin
    if (!issue_vld)        act = ACT_NONE;
    else if (!exc_pending) act = ACT_EXEC;
    else if (native_mode)  act = ACT_REPORT;
    else if (ignore_err)   act = ACT_EXEC;
    else if (nowait_cls)   act = ACT_EXEC;
    else                   act = ACT_FREEZE;
  end
endmodule

// File: rtl/fpei_freeze.sv
module fpei_freeze (
  input  logic clk,
  input  logic rst,
  input  logic freeze_req,
  input  logic ext_intr,
  output logic frozen
);
  always_ff @(posedge clk) begin
    if (rst)                 frozen <= 1'b0;
    else if (frozen)         frozen <= !ext_intr;
    else if (freeze_req)     frozen <= 1'b1;
  end

  // R7
  hold_until_intr_chk: assert property (@(posedge clk) disable iff (rst)
    frozen && !ext_intr |=> frozen);
  // R8
  intr_release_chk: assert property (@(posedge clk) disable iff (rst)
    frozen && ext_intr |=> !frozen);
endmodule

// File: rtl/fp_err_ignore_ctl.sv
module fp_err_ignore_ctl
  import fpei_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic native_mode,
  input  logic exc_pending,
  input  logic ignore_err,
  input  logic issue_vld,
  input  logic nowait_cls,
  input  logic ext_intr,
  output logic exec_ok,
  output logic stall,
  output logic report_exc
);
  fpei_act_e act;
  logic      frozen;
  logic      exec_q, report_q;

  fpei_classify u_cls (
    .issue_vld  (issue_vld),
    .native_mode(native_mode),
    .exc_pending(exc_pending),
    .ignore_err (ignore_err),
    .nowait_cls (nowait_cls),
    .act        (act)
  );

  fpei_freeze u_frz (
    .clk       (clk),
    .rst       (rst),
    .freeze_req(!frozen && act == ACT_FREEZE),
    .ext_intr  (ext_intr),
    .frozen    (frozen)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      exec_q   <= 1'b0;
      report_q <= 1'b0;
    end else begin
      exec_q   <= !frozen && act == ACT_EXEC;
      report_q <= !frozen && act == ACT_REPORT;
    end
  end

  assign exec_ok    = exec_q;
  assign report_exc = report_q;
  assign stall      = frozen;

  // R10
  one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({exec_ok, stall, report_exc}));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !issue_vld |=> !exec_ok && !report_exc);
  // R3
  native_report_chk: assert property (@(posedge clk) disable iff (rst)
    !stall && issue_vld && exc_pending && native_mode |=> report_exc && !stall);
  // R2
  no_pending_exec_chk: assert property (@(posedge clk) disable iff (rst)
    !stall && issue_vld && !exc_pending |=> exec_ok);
endmodule

// File: tb/tb_fp_err_ignore_ctl.sv
module tb_fp_err_ignore_ctl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic native_mode = 0, exc_pending = 0, ignore_err = 0;
  logic issue_vld = 0, nowait_cls = 0, ext_intr = 0;
  logic exec_ok, stall, report_exc;

  int checks = 0;
  int errors = 0;
  bit frozen_m = 0;
  bit done = 0;

  typedef struct { logic [2:0] exp; string req; } item_t;
  item_t q[$];

  always #5 clk = ~clk;

  fp_err_ignore_ctl dut (
    .clk(clk), .rst(rst), .native_mode(native_mode), .exc_pending(exc_pending),
    .ignore_err(ignore_err), .issue_vld(issue_vld), .nowait_cls(nowait_cls),
    .ext_intr(ext_intr), .exec_ok(exec_ok), .stall(stall), .report_exc(report_exc)
  );

  // drive one cycle at the falling edge and queue the expected {exec,stall,report}
  task automatic step(input bit m, input bit p, input bit ig, input bit v,
                      input bit nw, input bit intr, input string req);
    item_t it;
    bit e_exec = 0, e_rep = 0;
    @(negedge clk);
    native_mode = m; exc_pending = p; ignore_err = ig;
    issue_vld = v; nowait_cls = nw; ext_intr = intr;
    if (frozen_m) begin
      if (intr) frozen_m = 0;
    end else if (v) begin
      if (!p)       e_exec = 1;
      else if (m)   e_rep = 1;
      else if (ig)  e_exec = 1;
      else if (nw)  e_exec = 1;
      else          frozen_m = 1;
    end
    it.exp = {e_exec, frozen_m, e_rep};
    it.req = req;
    q.push_back(it);
  endtask

  // monitor: compare after each rising edge
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if ({exec_ok, stall, report_exc} !== it.exp) begin
        errors++;
        $display("FAIL %s: {exec,stall,report} actual %b expected %b",
                 it.req, {exec_ok, stall, report_exc}, it.exp);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if ({exec_ok, stall, report_exc} !== 3'b000) begin
      errors++;
      $display("FAIL R1: actual %b expected 000", {exec_ok, stall, report_exc});
    end
    @(negedge clk); rst = 0;
    step(0,0,0,0,0,0,"R1");
    // R2: no pending, every mode/pin/class combination
    for (int k = 0; k < 8; k++) step(k[0], 0, k[1], 1, k[2], 0, "R2");
    // R3: native mode, pin ignored
    step(1,1,0,1,0,0,"R3");
    step(1,1,1,1,0,0,"R3");
    step(1,1,1,1,1,0,"R3");
    // R9: idle cycle
    step(1,1,1,0,0,0,"R9");
    step(0,0,0,0,1,0,"R9");
    // R4: pin override
    step(0,1,1,1,0,0,"R4");
    step(0,1,1,1,1,0,"R4");
    // R5: non-waiting bypass
    step(0,1,0,1,1,0,"R5");
    // R8: interrupt while running has no effect
    step(0,1,0,1,1,1,"R8");
    step(0,0,0,1,0,1,"R8");
    // R6: freeze
    step(0,1,0,1,0,0,"R6");
    // R7: pin and issues during stall
    step(0,1,1,1,0,0,"R7");
    step(0,0,0,1,1,0,"R7");
    step(1,1,0,1,0,0,"R7");
    step(0,1,1,0,0,0,"R7");
    // R8: release, issue on that cycle discarded
    step(0,0,0,1,0,1,"R8");
    step(0,0,0,1,0,0,"R8");
    // R6/R8: freeze again, idle, release with no issue
    step(0,1,0,1,0,0,"R6");
    step(0,0,0,0,0,0,"R7");
    step(0,0,0,0,0,1,"R8");
    step(0,1,0,1,1,0,"R5");
    step(0,0,0,0,0,0,"R9");
    // R6: freeze with interrupt in the same cycle still freezes
    step(0,1,0,1,0,1,"R6");
    step(0,0,0,0,0,1,"R8");
    step(0,0,0,0,0,0,"R10");
    @(negedge clk);
    issue_vld = 0; ext_intr = 0;
    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule